// File: doc/BRIEF.md
# GPIO Group Interrupt Controller

This block watches banks of general-purpose input pins and turns selected level or edge conditions into latched interrupt flags. Pins are arranged in groups of up to eight. Every pin has its own 4-bit trigger selector, a mask bit and a pending flag. Software reaches them over a plain memory-mapped register bus with single-cycle writes and registered reads.

Each pin input first passes through a two-flop synchroniser. A per-pin detector compares the synchronised value with the value from the previous cycle and applies the selected trigger. A hit sets the pin's pending flag. Software acknowledges a flag by writing one to it. A single interrupt line is high whenever any pending flag whose mask bit is clear is set.

There is no sequencing state in this block. Every pin is evaluated on every cycle, so the design consists of register arrays and a combinational trigger decoder with no state machine.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, all trigger fields read 0, all mask bits read 1 (bits 0 to PINS-1 of each mask word) and the interrupt output is low.
- R2: The trigger word of group g is at byte address 0x700 + 4*g. Pin n uses bits [4n+3:4n]. All 4*PINS bits are writable and read back as written, and bits above 4*PINS read 0.
- R3: The mask words are at 0x900 + 4*g and the pending words at 0xA00 + 4*g. Bit n of each word belongs to pin n, and bits at or above PINS read 0. Addresses that are unaligned, that point past the last group or that are otherwise unmapped read 0.
- R4: Code 3 (rising edge) sets the pending bit after a 0-to-1 change on the pin. The flag appears no earlier than the second and no later than the third rising clock edge after the input changes. A 1-to-0 change sets nothing.
- R5: Code 2 (falling edge) sets the pending bit on a 1-to-0 change and ignores a 0-to-1 change.
- R6: Code 4 (both edges) sets the pending bit on either change.
- R7: Code 1 (high level) and code 0 (low level) set the pending bit on every cycle in which the pin holds that level. While the level lasts, writing one to clear the bit leaves it set.
- R8: Codes 5 to 15 never set a pending bit, whatever the pin does.
- R9: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. Only a write of 1 to its own bit can clear a pending flag.
- R10: `irq_o` is high exactly when some pending bit has its mask bit at 0. Setting the mask bit hides the flag, and clearing the mask bit again raises the output if the flag is still pending.
- R11: A read returns its data on `bus_rdata` one clock edge after the request. `bus_rdata` holds its value on every cycle that carries no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| pins_i | input | NG*PINS | Raw pin inputs; bit g*PINS+n is pin n of group g |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with three groups of four pins. With four pins per group, the unused upper halves of the mask, pending and trigger words are present, so the read-as-zero bits of R2 and R3 can be checked. With three groups, the address just past the last group in each array can be reached. Every trigger code class is exercised on its own pin. Each class is checked against its opposite transition, and the level modes are checked against an attempted clear while the level is still active.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    typedef enum logic [3:0] {
        TRIG_LOW  = 4'd0,
        TRIG_HIGH = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_RISE = 4'd3,
        TRIG_BOTH = 4'd4
    } trig_e;

    // Decide whether one pin meets its trigger condition this cycle.
    function automatic logic trig_hit(input logic [3:0] code,
                                      input logic       cur,
                                      input logic       old);
        logic r;
        case (code)
            TRIG_LOW:  r = !cur;
            TRIG_HIGH: r = cur;
            TRIG_FALL: r = old && !cur;
            TRIG_RISE: r = !old && cur;
            TRIG_BOTH: r = old ^ cur;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/pin_trigger_detect.sv
module pin_trigger_detect
    import pin_irq_pkg::*;
#(
    parameter int PINS = 8,
    localparam int CW  = 4 * PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   cfg_i,
    input  logic [PINS-1:0] pin_s_i,
    output logic [PINS-1:0] hit_o
);
    logic [PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_s_i;
    end

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        always_comb begin
            hit_o[n] = trig_hit(cfg_i[4*n +: 4], pin_s_i[n], prev_q[n]);
        end
    end
endmodule

// File: rtl/pin_irq_regfile.sv
module pin_irq_regfile #(
    parameter int NG       = 21,
    parameter int PINS     = 8,
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int CFG_BASE = 'h700,
    parameter int MSK_BASE = 'h900,
    parameter int PND_BASE = 'hA00,
    localparam int CW      = 4 * PINS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NG*PINS-1:0] hit_i,
    output logic [NG*CW-1:0]   cfg_o,
    output logic [NG*PINS-1:0] mask_o,
    output logic [NG*PINS-1:0] pend_o
);
    logic          wr_en;
    logic          rd_en;
    logic [DW-1:0] rd_val;
    logic          unused_wdata;

    assign wr_en        = bus_sel && bus_wr;
    assign rd_en        = bus_sel && !bus_wr;
    assign unused_wdata = ^bus_wdata;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic          cfg_hit;
        logic          msk_hit;
        logic          pnd_hit;
        logic [PINS-1:0] clr;

        assign cfg_hit = wr_en && (bus_addr == AW'(CFG_BASE + 4*g));
        assign msk_hit = wr_en && (bus_addr == AW'(MSK_BASE + 4*g));
        assign pnd_hit = wr_en && (bus_addr == AW'(PND_BASE + 4*g));
        assign clr     = pnd_hit ? bus_wdata[PINS-1:0] : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_o[g*CW +: CW]    <= '0;
                mask_o[g*PINS +: PINS] <= '1;
                pend_o[g*PINS +: PINS] <= '0;
            end else begin
                if (cfg_hit) cfg_o[g*CW +: CW] <= bus_wdata[CW-1:0];
                if (msk_hit) mask_o[g*PINS +: PINS] <= bus_wdata[PINS-1:0];
                // a new hit wins over an acknowledge in the same cycle
                pend_o[g*PINS +: PINS] <= (pend_o[g*PINS +: PINS] & ~clr)
                                        | hit_i[g*PINS +: PINS];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int g = 0; g < NG; g++) begin
            if (bus_addr == AW'(CFG_BASE + 4*g)) rd_val[CW-1:0]   = cfg_o[g*CW +: CW];
            if (bus_addr == AW'(MSK_BASE + 4*g)) rd_val[PINS-1:0] = mask_o[g*PINS +: PINS];
            if (bus_addr == AW'(PND_BASE + 4*g)) rd_val[PINS-1:0] = pend_o[g*PINS +: PINS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
    parameter int NG       = 21,
    parameter int PINS     = 8,
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int CFG_BASE = 'h700,
    parameter int MSK_BASE = 'h900,
    parameter int PND_BASE = 'hA00,
    localparam int CW      = 4 * PINS,
    localparam int NPIN    = NG * PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN-1:0] pins_i,
    output logic            irq_o
);
    logic [NPIN-1:0]  pin_s;
    logic [NPIN-1:0]  hit_flat;
    logic [NG*CW-1:0] cfg_flat;
    logic [NPIN-1:0]  mask_flat;
    logic [NPIN-1:0]  pend_flat;

    pin_sync #(.W(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_i),
        .q_o   (pin_s)
    );

    for (genvar g = 0; g < NG; g++) begin : g_det
        pin_trigger_detect #(.PINS(PINS)) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_i   (cfg_flat[g*CW +: CW]),
            .pin_s_i (pin_s[g*PINS +: PINS]),
            .hit_o   (hit_flat[g*PINS +: PINS])
        );
    end

    pin_irq_regfile #(
        .NG(NG), .PINS(PINS), .AW(AW), .DW(DW),
        .CFG_BASE(CFG_BASE), .MSK_BASE(MSK_BASE), .PND_BASE(PND_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hit_i     (hit_flat),
        .cfg_o     (cfg_flat),
        .mask_o    (mask_flat),
        .pend_o    (pend_flat)
    );

    assign irq_o = |(pend_flat & ~mask_flat);
endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk #(
    parameter int NG       = 21,
    parameter int PINS     = 8,
    parameter int AW       = 12,
    parameter int DW       = 32,
    parameter int PND_BASE = 'hA00
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [AW-1:0]        bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic [DW-1:0]        bus_rdata,
    input logic                 irq_o,
    input logic [NG*4*PINS-1:0] cfg_flat,
    input logic [NG*PINS-1:0]   mask_flat,
    input logic [NG*PINS-1:0]   pend_flat
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && (&mask_flat)));

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_flat) |-> !irq_o);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata));

    for (genvar g = 0; g < NG; g++) begin : g_grp
        for (genvar n = 0; n < PINS; n++) begin : g_pin
            localparam int I = g * PINS + n;
            // R8
            valid_code_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend_flat[I]) |-> ($past(cfg_flat[4*I +: 4]) <= 4'd4));
            // R9
            w1c_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend_flat[I]) |->
                    $past(bus_sel && bus_wr && bus_addr == AW'(PND_BASE + 4*g) && bus_wdata[n]));
        end
    end
endmodule

bind pin_event_irq pin_event_irq_chk #(
    .NG(NG), .PINS(PINS), .AW(AW), .DW(DW), .PND_BASE(PND_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .cfg_flat  (cfg_flat),
    .mask_flat (mask_flat),
    .pend_flat (pend_flat)
);

// File: tb/pin_event_irq_test.sv
`timescale 1ns/1ps
module pin_event_irq_test;
    localparam int NG = 3;
    localparam int P  = 4;
    localparam int AW = 12;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [NG*P-1:0]   pins = '0;
    logic              irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] exp;
        string         tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #2 clk = ~clk;

    pin_event_irq #(.NG(NG), .PINS(P), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_i(pins), .irq_o(irq_o)
    );

    function automatic logic [AW-1:0] cfg_a(int g); return AW'('h700 + 4*g); endfunction
    function automatic logic [AW-1:0] msk_a(int g); return AW'('h900 + 4*g); endfunction
    function automatic logic [AW-1:0] pnd_a(int g); return AW'('hA00 + 4*g); endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: issues a read and pushes the expected word to the scoreboard
    task automatic bus_read(logic [AW-1:0] a, logic [DW-1:0] e, string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // monitor: read data lands one edge after the request
    always @(posedge clk) begin
        if (rst_n && bus_sel && !bus_wr) begin
            #1;
            if (sb_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R11: actual read with no expected item, expected none");
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 irq after reset", DW'(irq_o), 0);
        bus_read(cfg_a(0), 0, "R1 cfg reset");
        bus_read(msk_a(1), 'hF, "R1 mask reset");
        bus_read(msk_a(2), 'hF, "R1 mask reset");

        // disable all pins, then acknowledge what low-level mode latched
        for (int g = 0; g < NG; g++) bus_write(cfg_a(g), 'h5555);
        for (int g = 0; g < NG; g++) bus_write(pnd_a(g), 'hF);
        for (int g = 0; g < NG; g++) bus_read(pnd_a(g), 0, "R9 clear all");

        // R8: disabled codes 5 and 15
        bus_write(cfg_a(0), 'h55F5);
        pins[0] = 1; pins[1] = 1; tick(4);
        pins[0] = 0; pins[1] = 0; tick(4);
        bus_read(pnd_a(0), 0, "R8 disabled codes");

        // R4: rising edge with latency
        bus_write(cfg_a(0), 'h5553);
        bus_write(msk_a(0), 'hE);
        pins[0] = 1;
        tick(2);
        check("R4 not before second edge", DW'(irq_o), 0);
        tick(1);
        check("R4 set by third edge", DW'(irq_o), 1);
        bus_read(pnd_a(0), 'h1, "R4 pending");
        bus_write(pnd_a(0), 'h1);
        check("R9 irq after ack", DW'(irq_o), 0);
        pins[0] = 0; tick(4);
        bus_read(pnd_a(0), 0, "R4 fall ignored");

        // R5: falling edge
        bus_write(cfg_a(0), 'h5523);
        pins[1] = 1; tick(4);
        bus_read(pnd_a(0), 0, "R5 rise ignored");
        pins[1] = 0; tick(4);
        bus_read(pnd_a(0), 'h2, "R5 fall sets");
        bus_write(pnd_a(0), 'h2);
        bus_read(pnd_a(0), 0, "R9 fall cleared");

        // R6: both edges
        bus_write(cfg_a(0), 'h5423);
        pins[2] = 1; tick(4);
        bus_read(pnd_a(0), 'h4, "R6 rise sets");
        bus_write(pnd_a(0), 'h4);
        pins[2] = 0; tick(4);
        bus_read(pnd_a(0), 'h4, "R6 fall sets");
        bus_write(pnd_a(0), 'h4);
        bus_read(pnd_a(0), 0, "R6 cleared");

        // R7: level high, clear has no effect while active
        bus_write(cfg_a(1), 'h1555);
        pins[7] = 1; tick(4);
        bus_read(pnd_a(1), 'h8, "R7 high level sets");
        bus_write(pnd_a(1), 'h8);
        bus_read(pnd_a(1), 'h8, "R7 clear while active");
        pins[7] = 0; tick(4);
        bus_write(pnd_a(1), 'h8);
        bus_read(pnd_a(1), 0, "R7 clear after level gone");
        // R7: level low
        bus_write(cfg_a(2), 'h5550);
        tick(4);
        bus_read(pnd_a(2), 'h1, "R7 low level sets");
        pins[8] = 1; tick(4);
        bus_write(pnd_a(2), 'h1);
        bus_read(pnd_a(2), 0, "R7 low cleared");

        // R9: write 0 keeps, write 1 clears only its own bit
        pins[0] = 1; pins[2] = 1; tick(4);
        bus_read(pnd_a(0), 'h5, "R9 two set");
        bus_write(pnd_a(0), 'h4);
        bus_read(pnd_a(0), 'h1, "R9 selective clear");
        bus_write(pnd_a(0), 'h0);
        bus_read(pnd_a(0), 'h1, "R9 zero write keeps");

        // R10: masking
        check("R10 unmasked pending", DW'(irq_o), 1);
        bus_write(msk_a(0), 'hF);
        check("R10 masked", DW'(irq_o), 0);
        bus_write(msk_a(0), 'hE);
        check("R10 unmask again", DW'(irq_o), 1);
        bus_write(msk_a(0), 'hF);
        bus_write(msk_a(1), 'h0);
        check("R10 unmasked but idle group", DW'(irq_o), 0);
        bus_write(msk_a(1), 'hF);
        bus_write(pnd_a(0), 'h1);

        // R3 / R2: address map and unused bits
        bus_write(msk_a(0), 'hFF);
        bus_read(msk_a(0), 'hF, "R3 mask unused bits");
        bus_read(AW'('h90C), 0, "R3 past last mask");
        bus_read(AW'('h902), 0, "R3 unaligned");
        bus_read(AW'('hA0C), 0, "R3 past last pending");
        bus_read(AW'('h800), 0, "R3 unmapped");
        bus_write(cfg_a(1), 'hFFFF_FFFF);
        bus_read(cfg_a(1), 'hFFFF, "R2 cfg width");
        bus_read(AW'('h70C), 0, "R2 past last cfg");
        bus_read(cfg_a(0), 'h5423, "R2 cfg readback");

        // R11: rdata holds across non-read cycles
        held = 'h5423;
        bus_write(cfg_a(1), 'h5555);
        check("R11 hold after write", bus_rdata, held);
        tick(3);
        check("R11 hold idle", bus_rdata, held);

        tick(2);
        if (sb_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R11: actual %0d reads unanswered expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule